// File: doc/BRIEF.md
# Alternating-Block Reversible Cellular Automaton Engine

This block holds a binary grid on a torus and advances it one generation per clock when asked. Instead of looking at eight neighbours per cell, it cuts the grid into 2x2 tiles and rewrites each tile as a unit. The tiling changes from one generation to the next. On even generations the tiles start at even rows and columns. On odd generations every tile is shifted one cell down and one cell right, so the tiles along the last row and column wrap around to row 0 and column 0. Both built-in tile rules are reversible and keep the number of live cells unchanged.

A host writes a starting pattern one row per cycle and then pulses `step` as often as it needs. `rule_sel` chooses between two rules. The "swarm" rule moves pairs and triples around. The "collision" rule lets lone particles travel diagonally and makes head-on diagonal pairs bounce. Any row can be read back combinationally. A live-cell count shows at a glance that occupancy is conserved.

Top module: `ca_tile_engine`

## Requirements
- R1: After reset every cell is 0, `phase` is 0 (even tiling) and `pop_count` is 0.
- R2: With `load_en` high, `step` low and `load_row` < H, row `load_row` takes `load_data` at the clock edge. Bit c of a row is column c. The row reads back on `rd_data` once `rd_row` selects it.
- R3: A step never changes the total number of live cells, and `pop_count` always equals that total.
- R4: `phase` inverts on every step and holds when no step is issued.
- R5: In the even tiling, tile (i,j) covers rows 2i and 2i+1 and columns 2j and 2j+1. Its corners are NW=(2i,2j), NE=(2i,2j+1), SW=(2i+1,2j) and SE=(2i+1,2j+1), and these form tile bits 0 to 3.
- R6: In the odd tiling, the tile corners are (2i+1,2j+1), (2i+1,2j+2), (2i+2,2j+1) and (2i+2,2j+2), with all indices taken mod H for rows and mod W for columns. The last tile therefore joins rows H-1 and 0 with columns W-1 and 0.
- R7: With `rule_sel`=0 (swarm), a tile with exactly two live cells has every cell inverted. A tile with three live cells moves its empty cell to the diagonally opposite corner. Tiles with zero, one or four live cells are left unchanged.
- R8: With `rule_sel`=1 (collision), a lone live cell moves to the diagonally opposite corner. A diagonal pair (NW+SE or NE+SW) becomes the other diagonal. All other tiles are left unchanged.
- R9: When `load_en` and `step` are high in the same cycle, the step is performed and the load is discarded.
- R10: Under either rule the 16 tile states map to 16 distinct results.
- R11: With neither `step` nor `load_en` high, the grid keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rule_sel | input | 1 | 0 = swarm rule, 1 = collision rule |
| step | input | 1 | Advance one generation this cycle |
| load_en | input | 1 | Write one row this cycle |
| load_row | input | RW | Row index to write |
| load_data | input | W | Row contents, bit c = column c |
| rd_row | input | RW | Row index to read |
| rd_data | output | W | Contents of the selected row |
| phase | output | 1 | Tiling used by the next step, 0 = even |
| pop_count | output | PW | Number of live cells in the grid |

## Verification
The hardest case to reach from the ports is the wrap-around tile of the odd tiling. Its four corners sit at the far corners of the grid, and it only becomes active after an odd number of steps. To reach it, the bench first steps an empty grid once, which leaves the cells untouched but moves the tiling to odd. It then loads each of the 16 patterns into the four grid corners and steps again, once for each rule. The same exhaustive sweep on the even origin tile checks that each rule maps the 16 states to 16 distinct results. Long random runs with both rules compare every row against an arithmetic model after each step.

// File: rtl/ca_tile_pkg.sv
package ca_tile_pkg;

  typedef enum logic {
    RULE_SWARM     = 1'b0,
    RULE_COLLISION = 1'b1
  } tile_rule_e;

  // tile bit order: 0 = NW, 1 = NE, 2 = SW, 3 = SE
  function automatic logic [2:0] tile_weight(input logic [3:0] t);
    return {2'b00, t[0]} + {2'b00, t[1]} + {2'b00, t[2]} + {2'b00, t[3]};
  endfunction

  // reversing the bit order swaps each corner with its diagonal opposite
  function automatic logic [3:0] tile_mirror(input logic [3:0] t);
    return {t[0], t[1], t[2], t[3]};
  endfunction

  function automatic logic [3:0] swarm_next(input logic [3:0] t);
    logic [3:0] r;
    case (tile_weight(t))
      3'd2:    r = ~t;
      3'd3:    r = tile_mirror(t);
      default: r = t;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] collision_next(input logic [3:0] t);
    logic [3:0] r;
    if (tile_weight(t) == 3'd1)
      r = tile_mirror(t);
    else if (t == 4'b1001 || t == 4'b0110)
      r = ~t;
    else
      r = t;
    return r;
  endfunction

  function automatic int unsigned grid_count(input int unsigned n, input logic [1023:0] bits);
    int unsigned c;
    c = 0;
    for (int unsigned k = 0; k < n; k++) c += {31'd0, bits[k]};
    return c;
  endfunction

endpackage

// File: rtl/ca_tile_cell.sv
module ca_tile_cell
  import ca_tile_pkg::*;
(
  input  logic [3:0] tile_in,
  input  tile_rule_e rule,
  output logic [3:0] tile_out
);

  always_comb begin
    tile_out = (rule == RULE_COLLISION) ? collision_next(tile_in) : swarm_next(tile_in);
    a_r3_tile_keeps_count: assert ($countones(tile_out) == $countones(tile_in));
  end

endmodule

// File: rtl/ca_tile_sweep.sv
module ca_tile_sweep
  import ca_tile_pkg::*;
#(
  parameter int W  = 16,
  parameter int H  = 16,
  parameter int PH = 0
) (
  input  logic [H-1:0][W-1:0] cur,
  input  tile_rule_e          rule,
  output logic [H-1:0][W-1:0] nxt
);

  localparam int TR = H / 2;
  localparam int TC = W / 2;

  for (genvar ti = 0; ti < TR; ti++) begin : g_trow
    for (genvar tj = 0; tj < TC; tj++) begin : g_tcol
      localparam int R0 = (2 * ti + PH) % H;
      localparam int R1 = (R0 + 1) % H;
      localparam int C0 = (2 * tj + PH) % W;
      localparam int C1 = (C0 + 1) % W;

      logic [3:0] t_in;
      logic [3:0] t_out;

      assign t_in = {cur[R1][C1], cur[R1][C0], cur[R0][C1], cur[R0][C0]};

      ca_tile_cell u_cell (
        .tile_in  (t_in),
        .rule     (rule),
        .tile_out (t_out)
      );

      assign nxt[R0][C0] = t_out[0];
      assign nxt[R0][C1] = t_out[1];
      assign nxt[R1][C0] = t_out[2];
      assign nxt[R1][C1] = t_out[3];
    end
  end

endmodule

// File: rtl/ca_tile_popcnt.sv
module ca_tile_popcnt #(
  parameter int N  = 256,
  parameter int CW = $clog2(N + 1)
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] count
);

  always_comb begin
    count = '0;
    for (int k = 0; k < N; k++) count = count + CW'(bits[k]);
  end

endmodule

// File: rtl/ca_tile_engine.sv
module ca_tile_engine
  import ca_tile_pkg::*;
#(
  parameter  int W  = 16,
  parameter  int H  = 16,
  localparam int RW = (H > 1) ? $clog2(H) : 1,
  localparam int PW = $clog2(W * H + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rule_sel,
  input  logic          step,
  input  logic          load_en,
  input  logic [RW-1:0] load_row,
  input  logic [W-1:0]  load_data,
  input  logic [RW-1:0] rd_row,
  output logic [W-1:0]  rd_data,
  output logic          phase,
  output logic [PW-1:0] pop_count
);

  localparam int NCELL = W * H;

  logic [H-1:0][W-1:0] grid;
  logic [1:0][H-1:0][W-1:0] sweep_nxt;
  tile_rule_e rule;

  // named events for the checks
  logic step_fire;
  logic load_take;
  logic load_drop;
  logic load_row_ok;
  logic rd_row_ok;

  assign rule        = tile_rule_e'(rule_sel);
  assign load_row_ok = ({{(32-RW){1'b0}}, load_row} < H);
  assign rd_row_ok   = ({{(32-RW){1'b0}}, rd_row} < H);
  assign step_fire   = step;
  assign load_take   = load_en & ~step & load_row_ok;
  assign load_drop   = load_en & step;

  for (genvar p = 0; p < 2; p++) begin : g_align
    ca_tile_sweep #(.W(W), .H(H), .PH(p)) u_sweep (
      .cur  (grid),
      .rule (rule),
      .nxt  (sweep_nxt[p])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grid  <= '0;
      phase <= 1'b0;
    end else if (step_fire) begin
      grid  <= sweep_nxt[phase];
      phase <= ~phase;
    end else if (load_take) begin
      grid[load_row] <= load_data;
    end
  end

  assign rd_data = rd_row_ok ? grid[rd_row] : '0;

  ca_tile_popcnt #(.N(NCELL), .CW(PW)) u_pop (
    .bits  (grid),
    .count (pop_count)
  );

  // ---------------- checks ----------------
  a_r4_phase_flips: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> phase != $past(phase));

  a_r4_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !step_fire |=> phase == $past(phase));

  a_r3_pop_kept: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> pop_count == $past(pop_count));

  a_r9_load_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    load_drop |=> pop_count == $past(pop_count));

  a_r2_row_lands: assert property (@(posedge clk) disable iff (!rst_n)
    load_take |=> grid[$past(load_row)] == $past(load_data));

  a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_fire && !load_en) |=> grid == $past(grid));

endmodule

// File: tb/sim_ca_tile_engine.sv
`timescale 1ns/100ps
module sim_ca_tile_engine;

  localparam int W  = 4;
  localparam int H  = 4;
  localparam int RW = 2;
  localparam int PW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rule_sel = 1'b0;
  logic          step = 1'b0;
  logic          load_en = 1'b0;
  logic [RW-1:0] load_row = '0;
  logic [W-1:0]  load_data = '0;
  logic [RW-1:0] rd_row = '0;
  logic [W-1:0]  rd_data;
  logic          phase;
  logic [PW-1:0] pop_count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] mdl [H];
  int mphase = 0;
  int unsigned seed = 32'h1234_5677;

  always #2.5 clk = ~clk;

  ca_tile_engine #(.W(W), .H(H)) u0 (
    .clk, .rst_n, .rule_sel, .step, .load_en, .load_row, .load_data,
    .rd_row, .rd_data, .phase, .pop_count
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] ref_rule(input int rule, input logic [3:0] b);
    int n;
    logic [3:0] r;
    n = int'(b[0]) + int'(b[1]) + int'(b[2]) + int'(b[3]);
    r = b;
    if (rule == 0) begin
      if (n == 2) r = b ^ 4'hF;
      else if (n == 3)
        for (int k = 0; k < 4; k++) if (!b[k]) begin r = 4'hF; r[k] = 1'b1; r[3-k] = 1'b0; end
    end else begin
      if (n == 1)
        for (int k = 0; k < 4; k++) if (b[k]) begin r = 4'h0; r[3-k] = 1'b1; end
      if (b == 4'd9 || b == 4'd6) r = b ^ 4'hF;
    end
    return r;
  endfunction

  function automatic int mdl_pop();
    int c;
    c = 0;
    for (int r = 0; r < H; r++) for (int c2 = 0; c2 < W; c2++) c += int'(mdl[r][c2]);
    return c;
  endfunction

  function automatic void mdl_step(input int rule);
    logic [W-1:0] nx [H];
    for (int r = 0; r < H; r++) nx[r] = mdl[r];
    for (int i = 0; i < H / 2; i++)
      for (int j = 0; j < W / 2; j++) begin
        int r0, r1, c0, c1;
        logic [3:0] b, o;
        r0 = (2 * i + mphase) % H; r1 = (r0 + 1) % H;
        c0 = (2 * j + mphase) % W; c1 = (c0 + 1) % W;
        b = {mdl[r1][c1], mdl[r1][c0], mdl[r0][c1], mdl[r0][c0]};
        o = ref_rule(rule, b);
        nx[r0][c0] = o[0]; nx[r0][c1] = o[1]; nx[r1][c0] = o[2]; nx[r1][c1] = o[3];
      end
    for (int r = 0; r < H; r++) mdl[r] = nx[r];
    mphase = 1 - mphase;
  endfunction

  function automatic logic [W-1:0] rnd_row();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed[W-1:0];
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    for (int r = 0; r < H; r++) mdl[r] = '0;
    mphase = 0;
  endtask

  task automatic do_load(input int row, input logic [W-1:0] d);
    @(negedge clk); load_en = 1'b1; load_row = RW'(row); load_data = d;
    @(negedge clk); load_en = 1'b0;
    mdl[row] = d;
  endtask

  task automatic do_step(input int rule);
    @(negedge clk); step = 1'b1; rule_sel = rule[0];
    @(negedge clk); step = 1'b0;
    mdl_step(rule);
  endtask

  task automatic compare_all(input string req);
    for (int r = 0; r < H; r++) begin
      rd_row = RW'(r); #0.5;
      chk(rd_data == mdl[r], req, int'(rd_data), int'(mdl[r]));
    end
    chk(int'(pop_count) == mdl_pop(), "R3 pop_count", int'(pop_count), mdl_pop());
    chk(int'(phase) == mphase, "R4 phase", int'(phase), mphase);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit [15:0] seen;
    logic [3:0] got;
    do_reset();
    // R1 reset state
    compare_all("R1 reset grid");

    // R2 load and read back
    do_load(2, 4'b1010);
    compare_all("R2 row load");

    // R5 / R7 / R8 / R10: exhaustive even-tiling origin tile
    for (int rule = 0; rule < 2; rule++) begin
      seen = '0;
      for (int v = 0; v < 16; v++) begin
        do_reset();
        do_load(0, {2'b00, v[1], v[0]});
        do_load(1, {2'b00, v[3], v[2]});
        do_step(rule);
        compare_all(rule == 0 ? "R5 R7 swarm even tile" : "R5 R8 collision even tile");
        rd_row = 0; #0.5; got[1:0] = rd_data[1:0];
        rd_row = 1; #0.5; got[3:2] = rd_data[1:0];
        chk(!seen[got], "R10 distinct result", int'(got), v);
        seen[got] = 1'b1;
      end
    end

    // R6: wrap-around tile in the odd tiling
    for (int rule = 0; rule < 2; rule++)
      for (int v = 0; v < 16; v++) begin
        do_reset();
        do_step(rule);
        do_load(3, {v[0], 2'b00, v[1]});
        do_load(0, {v[2], 2'b00, v[3]});
        do_step(rule);
        compare_all("R6 odd wrap tile");
      end

    // R3 / R4: long random runs
    for (int rule = 0; rule < 2; rule++)
      for (int run = 0; run < 6; run++) begin
        do_reset();
        for (int r = 0; r < H; r++) do_load(r, rnd_row());
        for (int s = 0; s < 12; s++) begin
          do_step(rule);
          compare_all("R3 R4 random run");
        end
      end

    // R9: load in the same cycle as a step is discarded
    do_reset();
    for (int r = 0; r < H; r++) do_load(r, rnd_row());
    @(negedge clk);
    step = 1'b1; rule_sel = 1'b1; load_en = 1'b1; load_row = 2'd1; load_data = ~mdl[1];
    @(negedge clk);
    step = 1'b0; load_en = 1'b0;
    mdl_step(1);
    compare_all("R9 load during step");

    // R11: idle cycles keep the grid
    repeat (5) @(negedge clk);
    compare_all("R11 idle hold");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule